// File: doc/BRIEF.md
# GPIO change-detect interrupt controller

This block manages a small group of general-purpose pins, two by default. Software picks, per pin, whether it is an input or an output, and for outputs whether the driver is push-pull or open-drain. Outputs appear as separate value and enable signals per pin, so the pad cell outside the block does the actual driving.

For pins set as inputs, the block synchronizes the pad level and notices every change of level, in either direction. Each change sets a sticky status bit that stays set until software reads the status register, whatever the state of the interrupt enables. The enables only decide whether a latched change pulls the active-low alert line down. A summary flag reports that at least one status bit is set, for use by an enclosing status register.

Software reaches the block through a simple synchronous register bus with address, write data, read and write strobes, and registered read data.

Top module: `pin_event_ctrl`

## Requirements
- R1: After reset every register reads 0x00, all pins are inputs (pin_oe all 0), alert_n is 1 and sts_any is 0.
- R2: Registers direction (0xE0, bit=1 output), drive type (0xE1, bit=1 push-pull, 0 open-drain), output data (0xE4) and interrupt enable (0xE5) read back what was written, bit i for pin i, with bits at and above NPIN reading 0.
- R3: A rising or a falling level change on a pin set as input sets status bit i of the status register (0xE6); the bit is visible three clock edges after the pad changes.
- R4: A status bit sets on an input change even when that pin's interrupt enable is 0, and alert_n then stays 1.
- R5: alert_n is 0 while a status bit is set whose pin is an input with its enable bit at 1, and returns to 1 on the cycle after a read of the status register clears it.
- R6: A read of the status register returns the bits set so far and clears them; without such a read a set bit never clears.
- R7: A change detected in the same cycle as a status read is not returned by that read but remains set for the next read.
- R8: A level change on a pin set as output never sets its status bit.
- R9: sts_any is 1 exactly when any status bit is set.
- R10: A push-pull output pin has pin_oe=1 and pin_out equal to its output data bit from the cycle after the write.
- R11: An open-drain output pin has pin_out=0 and pin_oe=1 when its data bit is 0, and pin_oe=0 (released) when the bit is 1.
- R12: Reads of unmapped addresses return 0x00, and writes to the status register leave it unchanged.
- R13: An enable bit has no effect on alert_n while its pin is set as output, even if that pin's status bit is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| pin_in | input | NPIN | Pad input levels, asynchronous |
| pin_out | output | NPIN | Pad output value |
| pin_oe | output | NPIN | Pad output enable |
| alert_n | output | 1 | Active-low interrupt request |
| sts_any | output | 1 | Summary: some status bit is set |

## Verification
A wrong status register shows up on sts_any and, for enabled input pins, on alert_n three edges after a pad change, and again in the value a status read returns one cycle later. A wrong edge history shows as a missing or spurious status bit on the next read, while a lost event in a read-clear collision appears only on the second read after the collision. Wrong direction or drive-type state is visible on pin_oe and pin_out in the very next cycle after the write.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_DIR = 8'hE0;
  localparam logic [ADDR_W-1:0] ADDR_DRV = 8'hE1;
  localparam logic [ADDR_W-1:0] ADDR_OUT = 8'hE4;
  localparam logic [ADDR_W-1:0] ADDR_IEN = 8'hE5;
  localparam logic [ADDR_W-1:0] ADDR_STS = 8'hE6;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_DRV,
    SEL_OUT,
    SEL_IEN,
    SEL_STS
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      ADDR_DIR: s = SEL_DIR;
      ADDR_DRV: s = SEL_DRV;
      ADDR_OUT: s = SEL_OUT;
      ADDR_IEN: s = SEL_IEN;
      ADDR_STS: s = SEL_STS;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] is_out,
  output logic [NPIN-1:0] evt
);

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic meta_q, sync_q, prev_q;
    logic meta_d, sync_d, prev_d;

    always_comb begin
      meta_d = pin_in[g];
      sync_d = meta_q;
      prev_d = sync_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= meta_d;
        sync_q <= sync_d;
        prev_q <= prev_d;
      end
    end

    // a level change counts only while the pin is an input
    assign evt[g] = (sync_q ^ prev_q) & ~is_out[g];
  end

endmodule

// File: rtl/pin_regfile.sv
module pin_regfile
  import pin_event_pkg::*;
#(
  parameter int NPIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic              wr,
  input  logic [NPIN-1:0]   evt,
  output logic [DATA_W-1:0] rdata,
  output logic [NPIN-1:0]   dir_o,
  output logic [NPIN-1:0]   pp_o,
  output logic [NPIN-1:0]   out_o,
  output logic [NPIN-1:0]   ien_o,
  output logic [NPIN-1:0]   sts_o
);

  reg_sel_e          sel;
  logic [NPIN-1:0]   dir_q, dir_d;
  logic [NPIN-1:0]   pp_q, pp_d;
  logic [NPIN-1:0]   out_q, out_d;
  logic [NPIN-1:0]   ien_q, ien_d;
  logic [NPIN-1:0]   sts_q, sts_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] rd_val;
  logic              rd_sts;

  always_comb begin
    sel    = decode_addr(addr);
    rd_sts = rd && (sel == SEL_STS);

    dir_d = dir_q;
    pp_d  = pp_q;
    out_d = out_q;
    ien_d = ien_q;
    if (wr) begin
      case (sel)
        SEL_DIR: dir_d = wdata[NPIN-1:0];
        SEL_DRV: pp_d  = wdata[NPIN-1:0];
        SEL_OUT: out_d = wdata[NPIN-1:0];
        SEL_IEN: ien_d = wdata[NPIN-1:0];
        default: ;
      endcase
    end

    // clear-on-read loses to a change seen in the same cycle
    sts_d = (rd_sts ? '0 : sts_q) | evt;

    rd_val = '0;
    case (sel)
      SEL_DIR: rd_val[NPIN-1:0] = dir_q;
      SEL_DRV: rd_val[NPIN-1:0] = pp_q;
      SEL_OUT: rd_val[NPIN-1:0] = out_q;
      SEL_IEN: rd_val[NPIN-1:0] = ien_q;
      SEL_STS: rd_val[NPIN-1:0] = sts_q;
      default: ;
    endcase
    rdata_d = rd ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      pp_q    <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      sts_q   <= '0;
      rdata_q <= '0;
    end else begin
      dir_q   <= dir_d;
      pp_q    <= pp_d;
      out_q   <= out_d;
      ien_q   <= ien_d;
      sts_q   <= sts_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign dir_o = dir_q;
  assign pp_o  = pp_q;
  assign out_o = out_q;
  assign ien_o = ien_q;
  assign sts_o = sts_q;

endmodule

// File: rtl/pin_drive.sv
module pin_drive #(
  parameter int NPIN = 2
) (
  input  logic [NPIN-1:0] dir,
  input  logic [NPIN-1:0] pp,
  input  logic [NPIN-1:0] dat,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);

  for (genvar g = 0; g < NPIN; g++) begin : g_drv
    always_comb begin
      if (!dir[g]) begin
        pad_out[g] = 1'b0;
        pad_oe[g]  = 1'b0;
      end else if (pp[g]) begin
        pad_out[g] = dat[g];
        pad_oe[g]  = 1'b1;
      end else begin
        // open-drain: pull low for 0, release for 1
        pad_out[g] = 1'b0;
        pad_oe[g]  = ~dat[g];
      end
    end
  end

endmodule

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
  import pin_event_pkg::*;
#(
  parameter int NPIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              alert_n,
  output logic              sts_any
);

  logic            rst_meta_q, rst_n_s;
  logic [NPIN-1:0] dir_w, pp_w, out_w, ien_w, sts_w, evt_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  pin_sync_edge #(.NPIN(NPIN)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .pin_in (pin_in),
    .is_out (dir_w),
    .evt    (evt_w)
  );

  pin_regfile #(.NPIN(NPIN)) u_regs (
    .clk   (clk),
    .rst_n (rst_n_s),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rd    (bus_rd),
    .wr    (bus_wr),
    .evt   (evt_w),
    .rdata (bus_rdata),
    .dir_o (dir_w),
    .pp_o  (pp_w),
    .out_o (out_w),
    .ien_o (ien_w),
    .sts_o (sts_w)
  );

  pin_drive #(.NPIN(NPIN)) u_drive (
    .dir     (dir_w),
    .pp      (pp_w),
    .dat     (out_w),
    .pad_out (pin_out),
    .pad_oe  (pin_oe)
  );

  assign alert_n = ~|(sts_w & ien_w & ~dir_w);
  assign sts_any = |sts_w;

endmodule

// File: rtl/pin_event_chk.sv
module pin_event_chk
  import pin_event_pkg::*;
#(
  parameter int NPIN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic              alert_n,
  input logic              sts_any,
  input logic [NPIN-1:0]   dir_q,
  input logic [NPIN-1:0]   pp_q,
  input logic [NPIN-1:0]   ien_q,
  input logic [NPIN-1:0]   sts_q,
  input logic [NPIN-1:0]   evt
);

  logic rd_sts, rd_none;
  assign rd_sts  = bus_rd && (decode_addr(bus_addr) == SEL_STS);
  assign rd_none = bus_rd && (decode_addr(bus_addr) == SEL_NONE);

  assert_edge_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((sts_q & $past(evt)) == $past(evt)));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sts |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  assert_alert_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_n) |-> ((ien_q & ~dir_q) != '0));

  assert_alert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sts && (evt == '0)) |=> alert_n);

  assert_output_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~$past(sts_q) & $past(dir_q)) == '0);

  assert_summary_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_any) |-> $past(evt != '0));

  assert_od_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~pp_q & pin_out) == '0);

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_none |=> (bus_rdata == '0));

endmodule

bind pin_event_ctrl pin_event_chk #(.NPIN(NPIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .alert_n   (alert_n),
  .sts_any   (sts_any),
  .dir_q     (dir_w),
  .pp_q      (pp_w),
  .ien_q     (ien_w),
  .sts_q     (sts_w),
  .evt       (evt_w)
);

// File: tb/test_pin_event_ctrl.sv
`timescale 1ns/1ps
module test_pin_event_ctrl;

  localparam int NPIN = 2;
  localparam logic [7:0] A_DIR = 8'hE0;
  localparam logic [7:0] A_DRV = 8'hE1;
  localparam logic [7:0] A_OUT = 8'hE4;
  localparam logic [7:0] A_IEN = 8'hE5;
  localparam logic [7:0] A_STS = 8'hE6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [7:0]      bus_wdata = '0;
  logic            bus_rd = 1'b0;
  logic            bus_wr = 1'b0;
  logic [7:0]      bus_rdata;
  logic [NPIN-1:0] pin_in = '0;
  logic [NPIN-1:0] pin_out, pin_oe;
  logic            alert_n, sts_any;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  pin_event_ctrl #(.NPIN(NPIN)) i_pin_event_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alert_n(alert_n), .sts_any(sts_any)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: read data is registered, valid at the negedge after the strobe edge
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL scoreboard: unexpected read actual=%02h expected=none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(3);

    // R1 reset state
    chk("R1 alert_n", {7'd0, alert_n}, 8'h01);
    chk("R1 sts_any", {7'd0, sts_any}, 8'h00);
    chk("R1 pin_oe", {6'd0, pin_oe}, 8'h00);
    rd(A_DIR, 8'h00, "R1 dir");
    rd(A_DRV, 8'h00, "R1 drv");
    rd(A_OUT, 8'h00, "R1 out");
    rd(A_IEN, 8'h00, "R1 ien");
    rd(A_STS, 8'h00, "R1 sts");

    // R2 readback, upper bits zero
    wr(A_DIR, 8'hFF); rd(A_DIR, 8'h03, "R2 dir");
    wr(A_OUT, 8'hA5); rd(A_OUT, 8'h01, "R2 out");
    wr(A_DRV, 8'h02); rd(A_DRV, 8'h02, "R2 drv");
    wr(A_IEN, 8'hFE); rd(A_IEN, 8'h02, "R2 ien");
    wr(A_IEN, 8'h00);

    // R10 push-pull outputs
    wr(A_DRV, 8'h03); wr(A_OUT, 8'h02);
    chk("R10 oe", {6'd0, pin_oe}, 8'h03);
    chk("R10 out", {6'd0, pin_out}, 8'h02);
    // R11 open-drain outputs
    wr(A_DRV, 8'h00);
    chk("R11 oe", {6'd0, pin_oe}, 8'h01);
    chk("R11 out", {6'd0, pin_out}, 8'h00);

    // R8 changes on output pins are not recorded
    pin_in = 2'b11; cyc(5);
    pin_in = 2'b00; cyc(5);
    chk("R8 sts_any", {7'd0, sts_any}, 8'h00);
    wr(A_DIR, 8'h00);
    cyc(4);
    rd(A_STS, 8'h00, "R8 sts");

    // R3/R4/R9 rising edge, enable off
    pin_in = 2'b01; cyc(4);
    chk("R4 alert_n", {7'd0, alert_n}, 8'h01);
    chk("R9 sts_any", {7'd0, sts_any}, 8'h01);
    rd(A_STS, 8'h01, "R3 rise");
    rd(A_STS, 8'h00, "R6 cleared");
    chk("R9 sts_any clear", {7'd0, sts_any}, 8'h00);

    // R3 falling edge; R6 sticky over many cycles
    pin_in = 2'b00; cyc(20);
    rd(A_STS, 8'h01, "R3 fall sticky R6");

    // R5 alert for enabled input
    wr(A_IEN, 8'h02);
    pin_in = 2'b01; cyc(4);
    chk("R5 alert off pin0", {7'd0, alert_n}, 8'h01);
    pin_in = 2'b11; cyc(4);
    chk("R5 alert on", {7'd0, alert_n}, 8'h00);
    rd(A_STS, 8'h03, "R5 sts");
    chk("R5 alert release", {7'd0, alert_n}, 8'h01);

    // R13 enable ignored for output pins
    wr(A_IEN, 8'h03);
    pin_in = 2'b10; cyc(4);
    chk("R13 alert input", {7'd0, alert_n}, 8'h00);
    wr(A_DIR, 8'h01);
    chk("R13 alert masked", {7'd0, alert_n}, 8'h01);
    wr(A_DIR, 8'h00);
    chk("R13 alert back", {7'd0, alert_n}, 8'h00);

    // R12 write to status ignored, unmapped read zero
    wr(A_STS, 8'h00);
    rd(A_STS, 8'h01, "R12 sts write ignored");
    wr(A_STS, 8'hFF);
    rd(A_STS, 8'h00, "R12 sts write no set");
    rd(8'h10, 8'h00, "R12 unmapped");
    rd(A_IEN + 8'h02, 8'h00, "R12 unmapped near");

    // R7 event collides with status read
    pin_in = 2'b00; cyc(2);
    rd(A_STS, 8'h00, "R7 old value");
    rd(A_STS, 8'h02, "R7 kept");
    rd(A_STS, 8'h00, "R7 cleared");

    cyc(3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule